// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a vector of general-purpose input pins and records interrupt events per pin in a raw status register. Each pin is set up on its own as edge-detecting or level-detecting. In edge mode the pin can fire on every transition or on one chosen transition. In level mode the pin fires while its value matches a chosen level. A mask picks which recorded events reach the single interrupt line. Software reads the raw status and the masked status over a simple register bus. It acknowledges events by writing ones to a clear register.

The pin values, the per-pin direction and a per-pin "input changed" strobe come from the pad logic that surrounds this block. Synchronisation and debouncing are done before the pins reach this block. Only pins whose direction bit is 0 (input) can record an event. Register writes take effect on the clock edge at which `bus_wr` is sampled high. Reads are combinational from `bus_addr`.

The block has no sequencing state machine. Its only state is the four configuration registers and the status register. Every cycle, the status register takes the pending bits, removes the bits being cleared, and then adds the newly detected events.

Top module: `gpio_irq_top`

## Requirements
- R1: While `rst_n` is low, all four configuration registers and the raw status register are zero. After reset, every register reads 0 and `irq` is 0.
- R2: The configuration registers sit at these offsets: sense at 0x404 (bit=1 level, 0 edge), both-edges at 0x408, event polarity at 0x40C and mask at 0x410. Each one is written in full by a bus write and reads back the value written.
- R3: A pin with sense=0 and both-edges=1 that is an input and has its changed strobe high sets its status bit on the next clock edge, whatever its data value.
- R4: A pin with sense=0 and both-edges=0 that is an input and has its changed strobe high sets its status bit only if its data bit equals its event bit. An event bit of 1 selects the rising edge and 0 selects the falling edge.
- R5: A pin with sense=1 that is an input sets its status bit on every clock edge at which its data bit equals its event bit. The changed strobe is not needed.
- R6: A pin whose direction bit is 1 (output) never sets its status bit.
- R7: Raw status reads at 0x414. Masked status (raw AND mask) reads at 0x418.
- R8: `irq` is high exactly when at least one bit of raw status AND mask is 1.
- R9: A write to 0x41C clears the raw status bits where the written data is 1 and leaves the other bits unchanged. A level condition that is still true sets its bit again.
- R10: When a set and a clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Writes to the status offsets 0x414 and 0x418 change nothing. Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, combinational from bus_addr |
| pin_data | input | PINS | Current pin values |
| pin_dir | input | PINS | Pin direction, 1 = output |
| pin_chg | input | PINS | Per-pin strobe, high for one cycle when an input changed |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions check every cycle that any-edge events and active levels on input pins land in the status register one edge later. They also check that output pins never raise a status bit, that a clear removes the bits it names on output pins, and that `irq` is never high while the status register is empty. The bench's scenarios are needed for the rest. These are register readback, single-edge polarity selection, partial clears, a level that re-asserts after a clear, the set-wins-over-clear collision, writes to read-only offsets being ignored, and reset in the middle of a run.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_EVT   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MSKD  = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h41C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_BOTH,
        SEL_EVT,
        SEL_MASK,
        SEL_RAW,
        SEL_MSKD,
        SEL_CLEAR
    } reg_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] sense_q,
    output logic [PINS-1:0] both_q,
    output logic [PINS-1:0] evt_q,
    output logic [PINS-1:0] mask_q,
    output logic [PINS-1:0] clr_vec
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            both_q  <= '0;
            evt_q   <= '0;
            mask_q  <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_SENSE: sense_q <= wdata;
                SEL_BOTH:  both_q  <= wdata;
                SEL_EVT:   evt_q   <= wdata;
                SEL_MASK:  mask_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_vec = '0;
        if (wr && sel == SEL_CLEAR) clr_vec = wdata;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int PINS = 8
) (
    input  logic [PINS-1:0] sense,
    input  logic [PINS-1:0] both,
    input  logic [PINS-1:0] evt,
    input  logic [PINS-1:0] data,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] chg,
    output logic [PINS-1:0] set_vec
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic match;
        logic edge_hit;
        logic lvl_hit;
        assign match    = (data[i] == evt[i]);
        assign edge_hit = !sense[i] && chg[i] && (both[i] || match);
        assign lvl_hit  = sense[i] && match;
        assign set_vec[i] = !dir[i] && (edge_hit || lvl_hit);
    end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_data,
    input  logic [PINS-1:0]   pin_dir,
    input  logic [PINS-1:0]   pin_chg,
    output logic              irq
);
    reg_sel_e        sel;
    logic [PINS-1:0] sense_q, both_q, evt_q, mask_q;
    logic [PINS-1:0] clr_vec, set_vec, raw_q, mskd;

    always_comb begin
        unique case (bus_addr)
            OFS_SENSE: sel = SEL_SENSE;
            OFS_BOTH:  sel = SEL_BOTH;
            OFS_EVT:   sel = SEL_EVT;
            OFS_MASK:  sel = SEL_MASK;
            OFS_RAW:   sel = SEL_RAW;
            OFS_MSKD:  sel = SEL_MSKD;
            OFS_CLEAR: sel = SEL_CLEAR;
            default:   sel = SEL_NONE;
        endcase
    end

    gpio_irq_cfg #(.PINS(PINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .sense_q (sense_q),
        .both_q  (both_q),
        .evt_q   (evt_q),
        .mask_q  (mask_q),
        .clr_vec (clr_vec)
    );

    gpio_irq_detect #(.PINS(PINS)) u_det (
        .sense   (sense_q),
        .both    (both_q),
        .evt     (evt_q),
        .data    (pin_data),
        .dir     (pin_dir),
        .chg     (pin_chg),
        .set_vec (set_vec)
    );

    // pending minus cleared, then new events on top: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | set_vec;
    end

    assign mskd = raw_q & mask_q;
    assign irq  = |mskd;

    always_comb begin
        unique case (sel)
            SEL_SENSE: bus_rdata = sense_q;
            SEL_BOTH:  bus_rdata = both_q;
            SEL_EVT:   bus_rdata = evt_q;
            SEL_MASK:  bus_rdata = mask_q;
            SEL_RAW:   bus_rdata = raw_q;
            SEL_MSKD:  bus_rdata = mskd;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   pin_data,
    input logic [PINS-1:0]   pin_dir,
    input logic [PINS-1:0]   pin_chg,
    input logic              irq,
    input logic [PINS-1:0]   raw_q,
    input logic [PINS-1:0]   sense_q,
    input logic [PINS-1:0]   both_q,
    input logic [PINS-1:0]   evt_q
);
    logic [PINS-1:0] any_edge, lvl_on;
    assign any_edge = pin_chg & ~pin_dir & ~sense_q & both_q;
    assign lvl_on   = ~pin_dir & sense_q & ~(pin_data ^ evt_q);

    // R3
    edge_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_edge != '0) |=> ((raw_q & $past(any_edge)) == $past(any_edge)));

    // R5
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_on != '0) |=> ((raw_q & $past(lvl_on)) == $past(lvl_on)));

    // R6
    out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & $past(pin_dir)) == '0));

    // R9
    clear_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLEAR) |=> ((raw_q & $past(bus_wdata & pin_dir)) == '0));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_q != '0));
endmodule

bind gpio_irq_top gpio_irq_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_data  (pin_data),
    .pin_dir   (pin_dir),
    .pin_chg   (pin_chg),
    .irq       (irq),
    .raw_q     (raw_q),
    .sense_q   (sense_q),
    .both_q    (both_q),
    .evt_q     (evt_q)
);

// File: tb/gpio_irq_top_test.sv
module gpio_irq_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_data = '0, pin_dir = '0, pin_chg = '0;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    gpio_irq_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_data(pin_data),
        .pin_dir(pin_dir), .pin_chg(pin_chg), .irq(irq)
    );

    // {sense, both, evt, dir, data, chg}
    localparam logic [47:0] VEC [6] = '{
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'h5A, 8'hFF},
        {8'h00, 8'h00, 8'hF0, 8'h00, 8'hCC, 8'hFF},
        {8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h0F},
        {8'hFF, 8'h00, 8'hAA, 8'h00, 8'hA5, 8'h00},
        {8'h0F, 8'hF0, 8'h33, 8'h3C, 8'h00, 8'hF0},
        {8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] c);
        @(negedge clk); pin_chg = c;
        @(negedge clk); pin_chg = '0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h404, v); check(v, 8'h00, "R1 sense");
        rd(12'h408, v); check(v, 8'h00, "R1 both");
        rd(12'h40C, v); check(v, 8'h00, "R1 evt");
        rd(12'h410, v); check(v, 8'h00, "R1 mask");
        rd(12'h414, v); check(v, 8'h00, "R1 raw");
        check({7'b0, irq}, 8'h00, "R1 irq");

        // R2 readback
        wr(12'h404, 8'hA5); wr(12'h408, 8'h3C); wr(12'h40C, 8'hF0); wr(12'h410, 8'h81);
        rd(12'h404, v); check(v, 8'hA5, "R2 sense");
        rd(12'h408, v); check(v, 8'h3C, "R2 both");
        rd(12'h40C, v); check(v, 8'hF0, "R2 evt");
        rd(12'h410, v); check(v, 8'h81, "R2 mask");

        // R3 R4 R5 R6 vector table
        for (int k = 0; k < 6; k++) begin
            logic [7:0] s, b, e, d, dt, c, exp;
            {s, b, e, d, dt, c} = VEC[k];
            exp = ~d & ((~s & c & (b | ~(dt ^ e))) | (s & ~(dt ^ e)));
            wr(12'h404, s); wr(12'h408, b); wr(12'h40C, e);
            @(negedge clk); pin_dir = d; pin_data = dt;
            wr(12'h41C, 8'hFF);
            pulse(c);
            rd(12'h414, v);
            check(v, exp, $sformatf("R3/R4/R5/R6 vector %0d", k));
        end

        // R7 R8 masked status and irq
        wr(12'h404, 8'h00); wr(12'h408, 8'hFF); wr(12'h40C, 8'h00); wr(12'h410, 8'h00);
        @(negedge clk); pin_dir = '0; pin_data = '0;
        wr(12'h41C, 8'hFF);
        pulse(8'h11);
        rd(12'h414, v); check(v, 8'h11, "R7 raw");
        rd(12'h418, v); check(v, 8'h00, "R7 masked none");
        check({7'b0, irq}, 8'h00, "R8 irq masked off");
        wr(12'h410, 8'h01);
        rd(12'h418, v); check(v, 8'h01, "R7 masked bit0");
        check({7'b0, irq}, 8'h01, "R8 irq on");

        // R9 partial clear
        wr(12'h41C, 8'h01);
        rd(12'h414, v); check(v, 8'h10, "R9 partial clear");
        check({7'b0, irq}, 8'h00, "R8 irq off after clear");
        wr(12'h41C, 8'h10);
        rd(12'h414, v); check(v, 8'h00, "R9 full clear");

        // R9 level re-set
        wr(12'h40C, 8'h01);
        @(negedge clk); pin_data = 8'h01;
        wr(12'h404, 8'h01);
        @(negedge clk);
        wr(12'h41C, 8'h01);
        rd(12'h414, v); check(v, 8'h01, "R9 level re-asserts");
        @(negedge clk); pin_data = 8'h00;
        wr(12'h41C, 8'h01);
        rd(12'h414, v); check(v, 8'h00, "R9 level gone clears");
        wr(12'h404, 8'h00);

        // R10 set beats clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h41C; bus_wdata = 8'h02; pin_chg = 8'h02;
        @(negedge clk);
        bus_wr = 1'b0; pin_chg = '0;
        rd(12'h414, v); check(v, 8'h02, "R10 set wins");

        // R11 read-only and unmapped
        wr(12'h414, 8'hFF); wr(12'h418, 8'hFF);
        rd(12'h414, v); check(v, 8'h02, "R11 status write ignored");
        rd(12'h500, v); check(v, 8'h00, "R11 unmapped 0x500");
        rd(12'h000, v); check(v, 8'h00, "R11 unmapped 0x000");

        // R1 mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'h414, v); check(v, 8'h00, "R1 raw after reset");
        rd(12'h408, v); check(v, 8'h00, "R1 both after reset");
        check({7'b0, irq}, 8'h00, "R1 irq after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule